// File: doc/BRIEF.md
# Bus Master with Backoff and Restart

This unit sits between a processor core and a shared system bus. The core hands it one single-beat read or write at a time. The unit latches the request and runs it on the bus. A bus cycle has an address phase, during which a strobe marks the cycle start, followed by a data phase that lasts until the target returns ready. When the cycle finishes, the core receives a one-clock done pulse and, for a read, the returned data.

System logic can take the bus away at any clock by asserting backoff. From the next clock the unit releases every cycle-driving output: address, write data and control strobes. If a cycle was in flight, it is dropped. Once backoff goes away, the same cycle runs again from its address phase, with the address, data and direction it had before. The unit never acknowledges a backoff.

Backoff has no effect while the hold-acknowledge status is high. While the stop-clock flag is high, backoff is not looked at and the last sample stands.

Top module: `bus_master_bo`

## Requirements
- R1: After reset the unit is idle: the strobe, address enable, data enable and done are low, the control enable is high, and read data is zero.
- R2: A start pulse taken while idle, with no backoff in effect, gives a strobe in the next clock, carrying the request's address and direction. The data phase follows and lasts until ready is sampled high (ready during the address phase is ignored). At that edge done pulses for one clock, and for a read, core read data takes the bus input sampled at that edge.
- R3: Effective backoff is backoff high while hold-acknowledge is low. When it is sampled at an edge, the control, address and data enables are all low from that edge until an edge that samples it low.
- R4: A cycle in progress when effective backoff is sampled is abandoned without a done pulse. The edge that samples backoff released starts the address phase again, with unchanged address, write data and direction.
- R5: Ready sampled at the same edge as effective backoff does not complete the cycle; the cycle is replayed.
- R6: While hold-acknowledge is high, backoff has no effect on the enables or on the cycle.
- R7: While the stop-clock flag is high, backoff is not sampled: the enables and the abort decision follow the last sample taken.
- R8: A start taken while effective backoff is in force is held and begins its address phase at the edge that samples backoff released.
- R9: A start pulse while a request is outstanding is ignored. The outstanding cycle keeps its address, and only one done results.
- R10: Backoff also floats the control enable while the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_start | input | 1 | One-clock request pulse from the core |
| core_write | input | 1 | Request direction, 1 = write |
| core_addr | input | AW | Request address |
| core_wdata | input | DW | Request write data |
| core_done | output | 1 | One-clock completion pulse |
| core_rdata | output | DW | Data of the last completed read |
| bus_addr | output | AW | Address driven to the bus |
| bus_dout | output | DW | Write data driven to the bus |
| bus_din | input | DW | Read data from the bus |
| bus_wr | output | 1 | Direction strobe, high during a write cycle |
| bus_ads | output | 1 | Address-phase strobe |
| bus_addr_oe | output | 1 | Drive enable for the address lines |
| bus_data_oe | output | 1 | Drive enable for the data lines |
| bus_ctl_oe | output | 1 | Drive enable for the control strobes |
| bus_ready | input | 1 | Target ready, completes the data phase |
| bus_backoff | input | 1 | System backoff request |
| bus_hlda | input | 1 | Hold-acknowledge status |
| stop_clk | input | 1 | Stop-clock state flag |

## Verification
A wrong backoff sample shows within one clock as an enable on the wrong side of a backoff edge. A sequencer left in the wrong phase shows at the next edge as a missing or extra address strobe. Corrupted latched request fields show up on the replayed address phase right after release, as a changed address, data or direction. A completion taken during an abort shows as a stray done pulse in the clock after the conflicting edge. Ready, backoff, hold-acknowledge and stop-clock are given random values and also directed overlaps, and every output is compared in every clock.

// File: rtl/bmb_pkg.sv
package bmb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  // Backoff decision for this edge: a frozen sample under stop-clock,
  // otherwise the raw input masked by hold-acknowledge.
  function automatic logic bo_effective(input logic held, input logic raw,
                                        input logic hlda, input logic stopc);
    return stopc ? held : (raw & ~hlda);
  endfunction

  // Phase advance when no backoff is in force.
  function automatic phase_e phase_step(input phase_e cur, input logic work,
                                        input logic rdy);
    phase_e nx;
    case (cur)
      PH_IDLE: nx = work ? PH_ADDR : PH_IDLE;
      PH_ADDR: nx = PH_DATA;
      PH_DATA: nx = rdy ? PH_IDLE : PH_DATA;
      default: nx = PH_IDLE;
    endcase
    return nx;
  endfunction
endpackage

// File: rtl/bmb_bo_sampler.sv
module bmb_bo_sampler
  import bmb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bus_backoff,
  input  logic bus_hlda,
  input  logic stop_clk,
  output logic bo_now,
  output logic bo_float
);
  assign bo_now = bo_effective(bo_float, bus_backoff, bus_hlda, stop_clk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bo_float <= 1'b0;
    else        bo_float <= bo_now;
  end

  // R7: under stop-clock the held sample must not move
  assert_stop_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_clk |=> $stable(bo_float));
endmodule

// File: rtl/bmb_req_hold.sv
module bmb_req_hold #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          clear,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  input  logic          in_write,
  output logic          valid,
  output logic [AW-1:0] lat_addr,
  output logic [DW-1:0] lat_wdata,
  output logic          lat_write
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid     <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_write <= 1'b0;
    end else if (clear) begin
      valid <= 1'b0;
    end else if (capture) begin
      valid     <= 1'b1;
      lat_addr  <= in_addr;
      lat_wdata <= in_wdata;
      lat_write <= in_write;
    end
  end

  // R4/R9: an outstanding request keeps its fields until it completes
  assert_fields_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !clear) |=> ($stable(lat_addr) && $stable(lat_wdata) && $stable(lat_write)));

  assert_no_double_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(capture && clear));
endmodule

// File: rtl/bmb_seq.sv
module bmb_seq
  import bmb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bo_now,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          core_start,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_din,
  output phase_e        phase,
  output logic          capture,
  output logic          clear,
  output logic          core_done,
  output logic [DW-1:0] core_rdata
);
  phase_e phase_nx;

  assign capture = core_start && !req_valid && (bo_now || phase == PH_IDLE);
  assign clear   = !bo_now && phase == PH_DATA && bus_ready;

  always_comb begin
    if (bo_now) phase_nx = PH_IDLE;
    else        phase_nx = phase_step(phase, req_valid || capture, bus_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      core_done  <= 1'b0;
      core_rdata <= '0;
    end else begin
      phase     <= phase_nx;
      core_done <= clear;
      if (clear && !req_write) core_rdata <= bus_din;
    end
  end

  // R4: backoff during a cycle abandons it with no completion
  assert_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bo_now && phase != PH_IDLE) |=> (phase == PH_IDLE && !core_done));

  // R2: done is a single-clock pulse
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> !core_done);

  // R2: address phase always moves on to data phase unless backed off
  assert_addr_to_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ADDR && !bo_now) |=> phase == PH_DATA);
endmodule

// File: rtl/bus_master_bo.sv
module bus_master_bo
  import bmb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_start,
  input  logic          core_write,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  output logic          core_done,
  output logic [DW-1:0] core_rdata,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  input  logic [DW-1:0] bus_din,
  output logic          bus_wr,
  output logic          bus_ads,
  output logic          bus_addr_oe,
  output logic          bus_data_oe,
  output logic          bus_ctl_oe,
  input  logic          bus_ready,
  input  logic          bus_backoff,
  input  logic          bus_hlda,
  input  logic          stop_clk
);
  logic          bo_now, bo_float;
  logic          capture, clear, req_valid, lat_write;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_wdata;
  phase_e        phase;
  logic          cyc_live;

  bmb_bo_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .bus_backoff(bus_backoff), .bus_hlda(bus_hlda),
    .stop_clk(stop_clk), .bo_now(bo_now), .bo_float(bo_float)
  );

  bmb_req_hold #(.AW(AW), .DW(DW)) u_req (
    .clk(clk), .rst_n(rst_n), .capture(capture), .clear(clear),
    .in_addr(core_addr), .in_wdata(core_wdata), .in_write(core_write),
    .valid(req_valid), .lat_addr(lat_addr), .lat_wdata(lat_wdata),
    .lat_write(lat_write)
  );

  bmb_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .bo_now(bo_now), .req_valid(req_valid),
    .req_write(lat_write), .core_start(core_start), .bus_ready(bus_ready),
    .bus_din(bus_din), .phase(phase), .capture(capture), .clear(clear),
    .core_done(core_done), .core_rdata(core_rdata)
  );

  assign cyc_live    = (phase != PH_IDLE);
  assign bus_ctl_oe  = !bo_float;
  assign bus_addr_oe = !bo_float && cyc_live;
  assign bus_data_oe = !bo_float && cyc_live && lat_write;
  assign bus_ads     = !bo_float && phase == PH_ADDR;
  assign bus_wr      = cyc_live && lat_write;
  assign bus_addr    = lat_addr;
  assign bus_dout    = lat_wdata;

  // R3: effective backoff floats every drive enable at the next clock
  assert_float_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_backoff && !bus_hlda && !stop_clk) |=> (!bus_ctl_oe && !bus_addr_oe && !bus_data_oe));

  // R5: ready coinciding with backoff never completes
  assert_ready_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_backoff && !bus_hlda && !stop_clk && bus_ready) |=> !core_done);

  // R6: hold-acknowledge masks backoff
  assert_hlda_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_hlda && !stop_clk) |=> bus_ctl_oe);

  // R7: under stop-clock the control enable does not change
  assert_stop_clk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_clk |=> $stable(bus_ctl_oe));
endmodule

// File: tb/bus_master_bo_test.sv
module bus_master_bo_test;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic core_start = 0, core_write = 0;
  logic [AW-1:0] core_addr = '0;
  logic [DW-1:0] core_wdata = '0, bus_din = '0;
  logic bus_ready = 0, bus_backoff = 0, bus_hlda = 0, stop_clk = 0;
  logic core_done, bus_wr, bus_ads, bus_addr_oe, bus_data_oe, bus_ctl_oe;
  logic [DW-1:0] core_rdata, bus_dout;
  logic [AW-1:0] bus_addr;

  always #2 clk = ~clk;

  bus_master_bo #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .core_start(core_start), .core_write(core_write),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_done(core_done),
    .core_rdata(core_rdata), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .bus_din(bus_din), .bus_wr(bus_wr), .bus_ads(bus_ads),
    .bus_addr_oe(bus_addr_oe), .bus_data_oe(bus_data_oe),
    .bus_ctl_oe(bus_ctl_oe), .bus_ready(bus_ready), .bus_backoff(bus_backoff),
    .bus_hlda(bus_hlda), .stop_clk(stop_clk)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  string cur_tag = "R1";

  // Reference behaviour written from the requirements: step counts
  // 0 = no cycle, 1 = strobe clock, 2 = waiting for ready.
  int            m_step = 0;
  bit            m_have = 0, m_wr = 0, m_float = 0, m_done = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wd = '0, m_rd = '0;

  function automatic bit want_backoff(bit last, bit raw, bit hl, bit sc);
    if (sc) return last;
    return raw && !hl;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_step = 0; m_have = 0; m_wr = 0; m_float = 0; m_done = 0;
      m_addr = '0; m_wd = '0; m_rd = '0;
    end else begin
      bit b;
      b = want_backoff(m_float, bus_backoff, bus_hlda, stop_clk);
      m_float = b;
      m_done = 0;
      if (b) begin
        if (!m_have && core_start) begin
          m_have = 1; m_addr = core_addr; m_wd = core_wdata; m_wr = core_write;
        end
        m_step = 0;
      end else if (m_step == 0) begin
        if (!m_have && core_start) begin
          m_have = 1; m_addr = core_addr; m_wd = core_wdata; m_wr = core_write;
        end
        if (m_have) m_step = 1;
      end else if (m_step == 1) begin
        m_step = 2;
      end else if (bus_ready) begin
        m_done = 1; m_have = 0; m_step = 0;
        if (!m_wr) m_rd = bus_din;
      end
    end
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit live;
    string et;
    live = (m_step != 0);
    et = live ? "R3" : "R10";
    chk(et, "ctl_oe", bus_ctl_oe, !m_float);
    chk("R3", "addr_oe", bus_addr_oe, !m_float && live);
    chk("R3", "data_oe", bus_data_oe, !m_float && live && m_wr);
    chk(cur_tag, "ads", bus_ads, !m_float && m_step == 1);
    chk(cur_tag, "done", core_done, m_done);
    chk(cur_tag, "rdata", core_rdata, m_rd);
    if (live) begin
      chk(cur_tag, "wr", bus_wr, m_wr);
      chk(cur_tag, "addr", bus_addr, m_addr);
      if (m_wr) chk(cur_tag, "dout", bus_dout, m_wd);
    end else begin
      chk(cur_tag, "wr_idle", bus_wr, 1'b0);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic issue(bit wr, logic [AW-1:0] a, logic [DW-1:0] d);
    core_start = 1; core_write = wr; core_addr = a; core_wdata = d;
    tick();
    core_start = 0;
  endtask

  task automatic wait_step(int s);
    while (m_step != s) tick();
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0b0f));
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_tag = "R1";
    tick();
    // Explicit reset-state checks (R1)
    chk("R1", "reset ads", bus_ads, 1'b0);
    chk("R1", "reset ctl_oe", bus_ctl_oe, 1'b1);

    // R2: plain read then write
    cur_tag = "R2";
    bus_din = 32'hCAFE_0001;
    issue(0, 16'h1234, 32'h0);
    bus_ready = 1; // ready during address phase must be ignored
    tick(); tick();
    bus_ready = 0;
    repeat (2) tick();
    issue(1, 16'h2222, 32'hA5A5_5A5A);
    wait_step(2); bus_ready = 1; tick(); bus_ready = 0; tick();

    // R4: backoff in the address phase, then in the data phase
    cur_tag = "R4";
    issue(1, 16'h4444, 32'h1357_9BDF);
    bus_backoff = 1; repeat (3) tick(); bus_backoff = 0;
    wait_step(2); tick();
    bus_backoff = 1; repeat (2) tick(); bus_backoff = 0;
    wait_step(2); bus_ready = 1; tick(); bus_ready = 0; tick();

    // R5: ready and backoff at the same edge
    cur_tag = "R5";
    bus_din = 32'hBEEF_0005;
    issue(0, 16'h5555, 32'h0);
    wait_step(2);
    bus_ready = 1; bus_backoff = 1; tick();
    chk("R5", "no done on conflict", core_done, 1'b0);
    bus_ready = 0; tick(); bus_backoff = 0;
    wait_step(2); bus_ready = 1; tick(); bus_ready = 0; tick();

    // R6: hold-acknowledge masks backoff
    cur_tag = "R6";
    bus_hlda = 1; bus_backoff = 1;
    issue(1, 16'h6666, 32'h0606_0606);
    repeat (3) tick();
    chk("R6", "ctl_oe under hlda", bus_ctl_oe, 1'b1);
    bus_ready = 1; tick(); bus_ready = 0;
    bus_hlda = 0; bus_backoff = 0; tick();

    // R7: stop-clock freezes the sample both ways
    cur_tag = "R7";
    bus_backoff = 1; tick();
    stop_clk = 1; bus_backoff = 0; repeat (3) tick();
    chk("R7", "still floated", bus_ctl_oe, 1'b0);
    stop_clk = 0; tick();
    stop_clk = 1; bus_backoff = 1; repeat (2) tick();
    chk("R7", "still driven", bus_ctl_oe, 1'b1);
    stop_clk = 0; bus_backoff = 0; tick();

    // R8 and R10: start during idle backoff waits for release
    cur_tag = "R8";
    bus_backoff = 1; tick();
    issue(0, 16'h8888, 32'h0);
    repeat (2) tick();
    chk("R8", "no strobe while backed off", bus_ads, 1'b0);
    bus_backoff = 0; tick();
    chk("R8", "strobe after release", bus_ads, 1'b1);
    wait_step(2); bus_ready = 1; tick(); bus_ready = 0; tick();

    // R9: second start while outstanding is dropped
    cur_tag = "R9";
    issue(1, 16'h9990, 32'h9);
    issue(0, 16'h9991, 32'h0);
    wait_step(2); tick();
    chk("R9", "addr kept", bus_addr, 16'h9990);
    bus_ready = 1; tick(); bus_ready = 0;
    repeat (3) tick();

    // Random mix, compared every clock against the reference
    cur_tag = "R2";
    for (int i = 0; i < 4000; i++) begin
      core_start = ($urandom % 4) == 0;
      core_write = $urandom % 2;
      core_addr  = AW'($urandom);
      core_wdata = $urandom;
      bus_din    = $urandom;
      bus_ready  = $urandom % 2;
      if (($urandom % 9) == 0) bus_backoff = !bus_backoff;
      bus_hlda   = ($urandom % 16) == 0;
      stop_clk   = ($urandom % 20) == 0;
      tick();
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule